// File: doc/BRIEF.md
# Iterative Subtractive GCD Engine

This block returns the greatest common divisor of two unsigned operands. It works one step per clock on a pair of working registers. If the first register is smaller than the second it exchanges them. Otherwise, while the second is non-zero, it subtracts the second from the first. When the second register reaches zero, the first register holds the answer.

Operands enter through a valid/ready request channel and the answer leaves through a valid/ready response channel. A transfer on either channel happens on a rising clock edge where both valid and ready are high. Only one computation runs at a time, and the request side stays not-ready until the consumer has taken the answer. The consumer may hold `res_ready` low for as long as it wants. The answer then stays on the port, unchanged, and no new operands are accepted.

A parameter picks the step rule. In the basic rule the exchange is a plain swap. In the fused rule the exchange also subtracts, which removes iterations.

Top module: `gcd_iter`

## Requirements
- R1: After reset, `opd_ready` is 1 and `res_valid` is 0.
- R2: Operands are captured only on an edge where `opd_valid` and `opd_ready` are both 1. Changes on `opd_x`/`opd_y` after that edge have no effect on the answer.
- R3: From the accepting edge until the answer has been taken, `opd_ready` stays 0.
- R4: With x, y in the working registers, each step does this. If x < y, the registers are swapped. Else if y != 0, x becomes x - y. Else the step ends the computation. The answer is gcd(x, y): gcd(15,5)=5, gcd(3,9)=3, gcd(0,0)=0, and gcd(v,0)=gcd(0,v)=v.
- R5: Let n be the number of steps under the active rule, counting the final step that finds y = 0. Then `res_valid` rises exactly n clock edges after the accepting edge.
- R6: With `FUSED_STEP`=1, the x < y case sets x to y - x and y to x in a single step. The answers are the same as with the basic rule.
- R7: Step counts, basic versus fused: gcd(3,9) takes 6 versus 5, gcd(27,15) takes 10 versus 8, gcd(21,49) takes 9 versus 7, and gcd(15,5) takes 5 under both rules.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_gcd` holds its value.
- R9: On the edge after a response transfer, `res_valid` is 0 and `opd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opd_valid | input | 1 | Operand pair offered |
| opd_ready | output | 1 | Engine idle, will accept operands |
| opd_x | input | WIDTH | First operand |
| opd_y | input | WIDTH | Second operand |
| res_valid | output | 1 | Answer available |
| res_ready | input | 1 | Consumer takes the answer |
| res_gcd | output | WIDTH | Greatest common divisor |

## Verification
The handshake assertions assume a producer that may raise `opd_valid` at any time and a consumer that may stall `res_ready` for any number of cycles. They do not assume that either side keeps its data steady after a transfer. The stimulus covers this by scrambling the operand inputs on every calculation cycle after acceptance. It also stalls `res_ready` for zero to two cycles, chosen per transaction. The monotone-sum check on the working registers holds for any 16-bit input, so the sweep and the large-value cases can use arbitrary operand pairs.

// File: rtl/gcd_iter_pkg.sv
package gcd_iter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_DONE = 2'd2
  } gcd_state_e;
endpackage

// File: rtl/gcd_iter_ctrl.sv
module gcd_iter_ctrl
  import gcd_iter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic opd_valid,
  input  logic res_ready,
  input  logic y_zero,
  output logic opd_ready,
  output logic res_valid,
  output logic load,
  output logic step
);
  gcd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (opd_valid) state_d = ST_CALC;
      ST_CALC: if (y_zero)    state_d = ST_DONE;
      ST_DONE: if (res_ready) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign opd_ready = (state_q == ST_IDLE);
  assign res_valid = (state_q == ST_DONE);
  assign load      = opd_ready && opd_valid;
  assign step      = (state_q == ST_CALC);

  AST_LOAD_ENTERS_CALC: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> step); // R2
  AST_ZERO_ENDS_CALC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && y_zero) |=> res_valid); // R5
endmodule

// File: rtl/gcd_iter_dpath.sv
module gcd_iter_dpath #(
  parameter int WIDTH      = 16,
  parameter bit FUSED_STEP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] in_x,
  input  logic [WIDTH-1:0] in_y,
  output logic             y_zero,
  output logic [WIDTH-1:0] result
);
  localparam int SUMW = WIDTH + 1;

  logic [WIDTH-1:0] x_q, y_q;
  logic [WIDTH-1:0] x_swap;
  logic             x_less;

  assign x_less = (x_q < y_q);
  assign y_zero = (y_q == '0);

  generate
    if (FUSED_STEP) begin : g_fused
      assign x_swap = y_q - x_q;
    end else begin : g_plain
      assign x_swap = y_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (load) begin
      x_q <= in_x;
      y_q <= in_y;
    end else if (step) begin
      if (x_less) begin
        x_q <= x_swap;
        y_q <= x_q;
      end else if (!y_zero) begin
        x_q <= x_q - y_q;
      end
    end
  end

  assign result = x_q;

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (x_q == $past(in_x) && y_q == $past(in_y))); // R2
  AST_SUM_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !y_zero) |=>
      (({1'b0, x_q} + {1'b0, y_q}) <= $past({1'b0, x_q} + {1'b0, y_q}))); // R4
endmodule

// File: rtl/gcd_iter.sv
module gcd_iter #(
  parameter int WIDTH      = 16,
  parameter bit FUSED_STEP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opd_valid,
  output logic             opd_ready,
  input  logic [WIDTH-1:0] opd_x,
  input  logic [WIDTH-1:0] opd_y,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [WIDTH-1:0] res_gcd
);
  logic load, step, y_zero;

  gcd_iter_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .opd_valid (opd_valid),
    .res_ready (res_ready),
    .y_zero    (y_zero),
    .opd_ready (opd_ready),
    .res_valid (res_valid),
    .load      (load),
    .step      (step)
  );

  gcd_iter_dpath #(.WIDTH(WIDTH), .FUSED_STEP(FUSED_STEP)) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step   (step),
    .in_x   (opd_x),
    .in_y   (opd_y),
    .y_zero (y_zero),
    .result (res_gcd)
  );

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !opd_ready); // R3
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (opd_valid && opd_ready) |=> !opd_ready); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_gcd))); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (!res_valid && opd_ready)); // R9
endmodule

// File: tb/test_gcd_iter.sv
`timescale 1ns/1ps
module test_gcd_iter;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] px, py;
  logic rv [2];
  logic rr [2];
  logic sv [2];
  logic sr [2];
  logic [W-1:0] res [2];

  int checks = 0;
  int fails  = 0;

  gcd_iter #(.WIDTH(W), .FUSED_STEP(1'b0)) i_gcd_iter (
    .clk(clk), .rst_n(rst_n), .opd_valid(rv[0]), .opd_ready(rr[0]),
    .opd_x(px), .opd_y(py), .res_valid(sv[0]), .res_ready(sr[0]), .res_gcd(res[0]));

  gcd_iter #(.WIDTH(W), .FUSED_STEP(1'b1)) i_gcd_iter_fused (
    .clk(clk), .rst_n(rst_n), .opd_valid(rv[1]), .opd_ready(rr[1]),
    .opd_x(px), .opd_y(py), .res_valid(sv[1]), .res_ready(sr[1]), .res_gcd(res[1]));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_gcd(input int a, input int b);
    int t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  function automatic int ref_steps(input int a, input int b, input bit fused);
    int n = 0;
    int t;
    forever begin
      n++;
      if (a < b) begin
        if (fused) begin t = b - a; b = a; a = t; end
        else begin t = b; b = a; a = t; end
      end else if (b != 0) a = a - b;
      else return n;
    end
  endfunction

  task automatic run(input int a, input int b, input int hold);
    int phase [2];
    int lat [2];
    int cnt [2];
    logic [W-1:0] held [2];
    bit busy_ok [2];
    @(negedge clk);
    px = W'(a); py = W'(b);
    for (int i = 0; i < 2; i++) begin
      rv[i] = 1'b1; sr[i] = 1'b0; phase[i] = 0; lat[i] = 0; busy_ok[i] = 1'b1;
    end
    for (int c = 0; c < 100000; c++) begin
      for (int i = 0; i < 2; i++) begin
        case (phase[i])
          0: if (rr[i]) phase[i] = 1;
          1: begin
            rv[i] = 1'b0;
            lat[i]++;
            px = ~W'(a + c); py = W'(b * 7 + c);   // R2: scramble after capture
            if (rr[i]) busy_ok[i] = 1'b0;
            if (sv[i]) begin
              chk(res[i] == W'(ref_gcd(a, b)), i ? "R6 fused result" : "R4 result",
                  res[i], ref_gcd(a, b));
              chk(lat[i] == ref_steps(a, b, i[0]) + 1, "R5 latency",
                  lat[i] - 1, ref_steps(a, b, i[0]));
              chk(busy_ok[i], "R3 ready low while busy", 1, 0);
              held[i] = res[i];
              if (hold == 0) begin sr[i] = 1'b1; phase[i] = 3; end
              else begin cnt[i] = hold; phase[i] = 2; end
            end
          end
          2: begin
            chk(sv[i] && res[i] == held[i], "R8 stall holds", res[i], held[i]);
            chk(!rr[i], "R3 ready low while stalled", rr[i], 0);
            cnt[i]--;
            if (cnt[i] == 0) begin sr[i] = 1'b1; phase[i] = 3; end
          end
          3: begin
            chk(!sv[i] && rr[i], "R9 release", {sv[i], rr[i]}, 1);
            sr[i] = 1'b0;
            phase[i] = 4;
          end
          default: ;
        endcase
      end
      if (phase[0] == 4 && phase[1] == 4) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    px = '0; py = '0;
    for (int i = 0; i < 2; i++) begin rv[i] = 1'b0; sr[i] = 1'b0; end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++)
      chk(rr[i] && !sv[i], "R1 reset state", {rr[i], sv[i]}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rr[0] && !sv[0], "R1 idle after reset", {rr[0], sv[0]}, 2);

    // R7: step counts of the reference rule against fixed values
    chk(ref_steps(3, 9, 0) == 6 && ref_steps(3, 9, 1) == 5, "R7 3,9", ref_steps(3, 9, 1), 5);
    chk(ref_steps(27, 15, 0) == 10 && ref_steps(27, 15, 1) == 8, "R7 27,15", ref_steps(27, 15, 1), 8);
    chk(ref_steps(21, 49, 0) == 9 && ref_steps(21, 49, 1) == 7, "R7 21,49", ref_steps(21, 49, 1), 7);
    chk(ref_steps(15, 5, 0) == 5 && ref_steps(15, 5, 1) == 5, "R7 15,5", ref_steps(15, 5, 1), 5);

    run(15, 5, 0);
    run(3, 9, 2);
    run(0, 0, 1);
    run(27, 15, 0);
    run(21, 49, 0);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run(a, b, (a + b) % 3);
    run(65535, 0, 0);
    run(0, 65535, 1);
    run(40000, 30000, 0);
    run(1000, 3, 2);
    run(65535, 65535, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule